// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard Interlock

This block is the interlock controller of an in-order, single-issue pipeline with six stages: fetch, decode, register read, ALU, memory and writeback. In every cycle the pipeline presents a description of the instruction held in each stage: a valid bit, a two-bit instruction class, a destination register number and two source register numbers. The memory stage also reports whether the branch it holds is taken, and to which address. From these inputs the block decides whether the front end must freeze, whether an empty slot goes into the ALU stage, which younger instructions are killed, and where fetch continues.

Source operands are read in the register-read stage and results are written in writeback. That is three stages apart, so an instruction in register read that depends on a producer in the ALU, memory or writeback stage has to wait. No forwarding network exists. Branches resolve late: the target and condition come out of the ALU stage, but the program counter changes only when the branch is in the memory stage. A taken branch therefore kills everything in stages 1 to 4. The block owns the fetch program counter. It steps the counter by a fixed increment, holds it during a stall, and loads the branch target on a redirect.

Top module: `interlock_top`

## Requirements
- R1: While reset is asserted the program counter `pc` is 0. With every stage invalid, `holdFront`, `bubbleAlu` and `flushYoung` are 0 and `pcSel` is 0 (advance).
- R2: A valid instruction in register read (stage index 2) whose source A or source B equals the non-zero destination of a valid ALU-class (code 0) or load-class (code 1) instruction in stage index 3, 4 or 5 raises `holdFront` and `bubbleAlu` and drives `pcSel` to 1 (hold).
- R3: Store-class (code 2) and branch-class (code 3) instructions never act as producers, whatever their destination field holds.
- R4: Register number 0 never creates a dependence, even when source and destination both equal 0.
- R5: An invalid consumer or an invalid producer never causes a hold.
- R6: A matching destination in fetch or decode (stage index 0 or 1) never causes a hold, because those instructions are younger than the consumer.
- R7: A valid branch-class instruction in the memory stage (stage index 4) with `brTaken` set drives `flushYoung` to the valid bits of stage indices 0 to 3 and drives `pcSel` to 2 (target). On the next clock edge `pc` takes `brTarget`.
- R8: A branch that is not taken, or a set `brTaken` with no valid branch in the memory stage, causes no flush and no redirect.
- R9: When a redirect and a register hazard occur in the same cycle, the redirect wins: `holdFront` and `bubbleAlu` stay 0 and `pcSel` is 2.
- R10: With neither hold nor redirect, `pc` advances by `PC_STEP` (4) at each clock edge. During a hold, `pc` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stageValid | input | 6 | Valid bit per stage; bit 0 is fetch, bit 5 is writeback |
| stageClass | input | 12 | Two-bit class per stage; stage s uses bits [2s+1:2s] |
| stageDest | input | 6*REG_W | Destination register per stage; stage s uses slice s |
| stageSrcA | input | 6*REG_W | First source register per stage |
| stageSrcB | input | 6*REG_W | Second source register per stage |
| brTaken | input | 1 | Branch outcome reported by the memory stage |
| brTarget | input | PC_W | Branch target reported by the memory stage |
| holdFront | output | 1 | Freeze the fetch, decode and register-read stage registers |
| bubbleAlu | output | 1 | Insert an invalid slot into the ALU stage |
| flushYoung | output | 4 | Kill mask for stage indices 0 to 3 |
| pcSel | output | 2 | Next-PC choice: 0 advance, 1 hold, 2 target |
| pc | output | PC_W | Fetch program counter |

## Verification
A taken branch in the memory stage and a register hazard at register read are the two events that can occur in the same cycle. To provoke the clash, the bench places a dependent consumer in register read and its ALU-class producer in the ALU stage, and in the same cycle presents a valid taken branch in the memory stage. It then expects the hold and bubble outputs to stay low, the kill mask to match the valid bits of the four younger stages, `pcSel` to read 2, and `pc` to hold the branch target after the next edge. This confirms that the redirect takes precedence and that the stall leaves no trace on the program counter.

// File: rtl/interlock_pkg.sv
package interlock_pkg;

  localparam int STAGES   = 6;
  localparam int RD_IDX   = 2;  // operands read here
  localparam int WB_IDX   = 5;  // results written here
  localparam int BR_IDX   = 4;  // branch redirects from here
  localparam int CLS_W    = 2;
  localparam int YOUNG_N  = BR_IDX;            // stages younger than the branch
  localparam int PROD_N   = WB_IDX - RD_IDX;   // producer window size

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU    = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_STORE  = 2'd2,
    CLS_BRANCH = 2'd3
  } instClass_e;

  typedef enum logic [1:0] {
    PC_ADVANCE = 2'd0,
    PC_HOLD    = 2'd1,
    PC_TARGET  = 2'd2
  } pcSel_e;

  typedef struct packed {
    logic hold;
    logic redirect;
  } pcStrobe_t;

endpackage

// File: rtl/interlock_ctrl.sv
module interlock_ctrl
  import interlock_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [STAGES-1:0]       stageValid,
  input  logic [STAGES*CLS_W-1:0] stageClass,
  input  logic [STAGES*REG_W-1:0] stageDest,
  input  logic [STAGES*REG_W-1:0] stageSrcA,
  input  logic [STAGES*REG_W-1:0] stageSrcB,
  input  logic                    brTaken,
  output logic                    stallFront,
  output logic [YOUNG_N-1:0]      killMask,
  output pcStrobe_t               strobe
);

  logic [REG_W-1:0] consSrcA;
  logic [REG_W-1:0] consSrcB;
  logic             consValid;
  logic [PROD_N-1:0] prodHit;
  logic             rawHazard;
  logic             redirect;
  instClass_e       brClass;

  // Lint sink: the full per-stage buses arrive, only some fields are consulted.
  logic unusedFields;
  assign unusedFields = ^{stageClass, stageDest, stageSrcA, stageSrcB};

  assign consValid = stageValid[RD_IDX];
  assign consSrcA  = stageSrcA[RD_IDX*REG_W +: REG_W];
  assign consSrcB  = stageSrcB[RD_IDX*REG_W +: REG_W];

  // One comparator pair per older stage that can still owe a write.
  for (genvar p = RD_IDX + 1; p <= WB_IDX; p++) begin : gProd
    instClass_e       pCls;
    logic [REG_W-1:0] pDest;
    logic             pWrites;
    assign pCls    = instClass_e'(stageClass[p*CLS_W +: CLS_W]);
    assign pDest   = stageDest[p*REG_W +: REG_W];
    assign pWrites = (pCls == CLS_ALU) || (pCls == CLS_LOAD);
    assign prodHit[p-RD_IDX-1] = stageValid[p] && pWrites && (pDest != '0) &&
                                 ((pDest == consSrcA) || (pDest == consSrcB));
  end

  assign rawHazard = consValid && (|prodHit);

  assign brClass  = instClass_e'(stageClass[BR_IDX*CLS_W +: CLS_W]);
  assign redirect = stageValid[BR_IDX] && (brClass == CLS_BRANCH) && brTaken;

  // Redirect outranks the data stall: the stalled consumer is being killed anyway.
  assign stallFront = rawHazard && !redirect;
  assign killMask   = redirect ? stageValid[YOUNG_N-1:0] : '0;

  assign strobe.hold     = stallFront;
  assign strobe.redirect = redirect;

endmodule

// File: rtl/interlock_pcpath.sv
module interlock_pcpath
  import interlock_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  pcStrobe_t       strobe,
  input  logic [PC_W-1:0] brTarget,
  output pcSel_e          sel,
  output logic [PC_W-1:0] pcQ
);

  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [PC_W-1:0] pcNext;

  always_comb begin
    if (strobe.redirect)  sel = PC_TARGET;
    else if (strobe.hold) sel = PC_HOLD;
    else                  sel = PC_ADVANCE;
  end

  always_comb begin
    unique case (sel)
      PC_TARGET: pcNext = brTarget;
      PC_HOLD:   pcNext = pcQ;
      default:   pcNext = pcQ + STEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= pcNext;
  end

endmodule

// File: rtl/interlock_top.sv
module interlock_top
  import interlock_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [interlock_pkg::STAGES-1:0] stageValid,
  input  logic [interlock_pkg::STAGES*interlock_pkg::CLS_W-1:0] stageClass,
  input  logic [interlock_pkg::STAGES*REG_W-1:0] stageDest,
  input  logic [interlock_pkg::STAGES*REG_W-1:0] stageSrcA,
  input  logic [interlock_pkg::STAGES*REG_W-1:0] stageSrcB,
  input  logic                          brTaken,
  input  logic [PC_W-1:0]               brTarget,
  output logic                          holdFront,
  output logic                          bubbleAlu,
  output logic [interlock_pkg::YOUNG_N-1:0] flushYoung,
  output logic [1:0]                    pcSel,
  output logic [PC_W-1:0]               pc
);

  pcStrobe_t strobe;
  pcSel_e    selInt;
  logic      stallFront;

  interlock_ctrl #(.REG_W(REG_W)) uCtrl (
    .stageValid (stageValid),
    .stageClass (stageClass),
    .stageDest  (stageDest),
    .stageSrcA  (stageSrcA),
    .stageSrcB  (stageSrcB),
    .brTaken    (brTaken),
    .stallFront (stallFront),
    .killMask   (flushYoung),
    .strobe     (strobe)
  );

  interlock_pcpath #(.PC_W(PC_W), .PC_STEP(PC_STEP)) uPc (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .brTarget (brTarget),
    .sel      (selInt),
    .pcQ      (pc)
  );

  assign holdFront = stallFront;
  assign bubbleAlu = stallFront;
  assign pcSel     = selInt;

endmodule

// File: rtl/interlock_chk.sv
module interlock_chk #(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [5:0]      stageValid,
  input logic            brTaken,
  input logic [PC_W-1:0] brTarget,
  input logic            holdFront,
  input logic            bubbleAlu,
  input logic [3:0]      flushYoung,
  input logic [1:0]      pcSel,
  input logic [PC_W-1:0] pc
);

  // R9: a redirect and a hold never coexist
  a_r9_redirect_beats_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pcSel == 2'd2) |-> !holdFront && !bubbleAlu);

  // R7: the kill mask only touches occupied younger stages
  a_r7_kill_only_valid: assert property (@(posedge clk) disable iff (!rstN)
    (flushYoung & ~stageValid[3:0]) == 4'd0);

  // R7: a target selection loads the target on the next edge
  a_r7_target_loaded: assert property (@(posedge clk) disable iff (!rstN)
    (pcSel == 2'd2) |=> pc == $past(brTarget));

  // R10: a hold keeps the program counter
  a_r10_hold_keeps_pc: assert property (@(posedge clk) disable iff (!rstN)
    holdFront |=> $stable(pc));

  // R10: the plain path steps by the fixed increment
  a_r10_advance_step: assert property (@(posedge clk) disable iff (!rstN)
    (!holdFront && pcSel != 2'd2) |=> pc == $past(pc) + PC_W'(PC_STEP));

  // R5: no hold without an occupant in register read
  a_r5_hold_needs_consumer: assert property (@(posedge clk) disable iff (!rstN)
    holdFront |-> stageValid[2]);

  // R8: no flush without a valid memory-stage occupant and a taken outcome
  a_r8_flush_needs_branch: assert property (@(posedge clk) disable iff (!rstN)
    (flushYoung != 4'd0) |-> stageValid[4] && brTaken);

endmodule

bind interlock_top interlock_chk #(.PC_W(PC_W), .PC_STEP(PC_STEP)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .stageValid (stageValid),
  .brTaken    (brTaken),
  .brTarget   (brTarget),
  .holdFront  (holdFront),
  .bubbleAlu  (bubbleAlu),
  .flushYoung (flushYoung),
  .pcSel      (pcSel),
  .pc         (pc)
);

// File: tb/sim_interlock_top.sv
`timescale 1ns/1ps
module sim_interlock_top;

  localparam int REG_W = 5;
  localparam int PC_W  = 32;
  localparam logic [1:0] C_ALU = 2'd0, C_LD = 2'd1, C_ST = 2'd2, C_BR = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] stageValid;
  logic [11:0] stageClass;
  logic [6*REG_W-1:0] stageDest, stageSrcA, stageSrcB;
  logic brTaken;
  logic [PC_W-1:0] brTarget;
  logic holdFront, bubbleAlu;
  logic [3:0] flushYoung;
  logic [1:0] pcSel;
  logic [PC_W-1:0] pc;

  int checks = 0;
  int failures = 0;
  logic [PC_W-1:0] pcBefore;

  always #4 clk = ~clk;  // 125 MHz

  interlock_top u0 (
    .clk(clk), .rstN(rstN), .stageValid(stageValid), .stageClass(stageClass),
    .stageDest(stageDest), .stageSrcA(stageSrcA), .stageSrcB(stageSrcB),
    .brTaken(brTaken), .brTarget(brTarget), .holdFront(holdFront),
    .bubbleAlu(bubbleAlu), .flushYoung(flushYoung), .pcSel(pcSel), .pc(pc)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic clearAll();
    stageValid = '0; stageClass = '0; stageDest = '0;
    stageSrcA = '0; stageSrcB = '0; brTaken = 1'b0; brTarget = '0;
  endtask

  task automatic setStage(input int s, input logic [1:0] cls, input logic [4:0] d,
                          input logic [4:0] a, input logic [4:0] b);
    stageValid[s] = 1'b1;
    stageClass[2*s +: 2] = cls;
    stageDest[s*REG_W +: REG_W] = d;
    stageSrcA[s*REG_W +: REG_W] = a;
    stageSrcB[s*REG_W +: REG_W] = b;
  endtask

  // Outputs are sampled 1 ns after the inputs change at a falling edge.
  task automatic expectComb(input string req, input logic h, input logic [3:0] f,
                            input logic [1:0] sel);
    #1;
    check({req, " hold"}, 32'(holdFront), 32'(h));
    check({req, " bubble"}, 32'(bubbleAlu), 32'(h));
    check({req, " flush"}, 32'(flushYoung), 32'(f));
    check({req, " pcSel"}, 32'(pcSel), 32'(sel));
  endtask

  task automatic expectPcAfterEdge(input string req, input logic [PC_W-1:0] exp);
    @(posedge clk); #1;
    check({req, " pc"}, pc, exp);
    @(negedge clk);
  endtask

  task automatic testReset();
    clearAll();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pc", pc, 32'd0);
    expectComb("R1 idle", 1'b0, 4'd0, 2'd0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testAdvance();
    clearAll();
    pcBefore = pc;
    expectComb("R10 idle", 1'b0, 4'd0, 2'd0);
    expectPcAfterEdge("R10 advance", pcBefore + 32'd4);
  endtask

  task automatic testRawWindow();
    for (int p = 3; p <= 5; p++) begin
      clearAll();
      setStage(2, C_ALU, 5'd0, 5'd7, 5'd9);
      setStage(p, (p == 4) ? C_LD : C_ALU, (p == 5) ? 5'd9 : 5'd7, 5'd1, 5'd2);
      pcBefore = pc;
      expectComb("R2 raw hold", 1'b1, 4'd0, 2'd1);
      expectPcAfterEdge("R10 hold", pcBefore);
    end
  endtask

  task automatic testNonProducers();
    clearAll();
    setStage(2, C_ALU, 5'd0, 5'd6, 5'd0);
    setStage(3, C_ST, 5'd6, 5'd1, 5'd2);
    setStage(4, C_BR, 5'd6, 5'd1, 5'd2);
    expectComb("R3 store/branch dest", 1'b0, 4'd0, 2'd0);
    @(negedge clk);
  endtask

  task automatic testRegZero();
    clearAll();
    setStage(2, C_ALU, 5'd3, 5'd0, 5'd0);
    setStage(3, C_ALU, 5'd0, 5'd1, 5'd1);
    setStage(5, C_LD, 5'd0, 5'd1, 5'd1);
    expectComb("R4 reg zero", 1'b0, 4'd0, 2'd0);
    @(negedge clk);
  endtask

  task automatic testInvalid();
    clearAll();
    setStage(2, C_ALU, 5'd0, 5'd8, 5'd0);
    setStage(3, C_ALU, 5'd8, 5'd1, 5'd1);
    stageValid[2] = 1'b0;
    expectComb("R5 invalid consumer", 1'b0, 4'd0, 2'd0);
    stageValid[2] = 1'b1; stageValid[3] = 1'b0;
    expectComb("R5 invalid producer", 1'b0, 4'd0, 2'd0);
    @(negedge clk);
  endtask

  task automatic testYounger();
    clearAll();
    setStage(2, C_ALU, 5'd0, 5'd11, 5'd12);
    setStage(0, C_ALU, 5'd11, 5'd1, 5'd1);
    setStage(1, C_LD, 5'd12, 5'd1, 5'd1);
    expectComb("R6 younger dest", 1'b0, 4'd0, 2'd0);
    @(negedge clk);
  endtask

  task automatic testTaken();
    clearAll();
    setStage(0, C_ALU, 5'd1, 5'd2, 5'd3);
    setStage(1, C_ALU, 5'd1, 5'd2, 5'd3);
    setStage(3, C_ST, 5'd0, 5'd2, 5'd3);
    setStage(4, C_BR, 5'd0, 5'd1, 5'd2);
    brTaken = 1'b1; brTarget = 32'h0000_0100;
    expectComb("R7 taken", 1'b0, 4'b1011, 2'd2);
    expectPcAfterEdge("R7 target", 32'h0000_0100);
  endtask

  task automatic testNotTaken();
    clearAll();
    setStage(0, C_ALU, 5'd1, 5'd2, 5'd3);
    setStage(4, C_BR, 5'd0, 5'd1, 5'd2);
    brTarget = 32'h0000_0800;
    pcBefore = pc;
    expectComb("R8 not taken", 1'b0, 4'd0, 2'd0);
    expectPcAfterEdge("R8 no redirect", pcBefore + 32'd4);
    clearAll();
    setStage(0, C_ALU, 5'd1, 5'd2, 5'd3);
    setStage(4, C_LD, 5'd4, 5'd1, 5'd2);
    brTaken = 1'b1; brTarget = 32'h0000_0800;
    expectComb("R8 taken without branch", 1'b0, 4'd0, 2'd0);
    @(negedge clk);
  endtask

  task automatic testPriority();
    clearAll();
    setStage(1, C_ALU, 5'd1, 5'd2, 5'd3);
    setStage(2, C_ALU, 5'd0, 5'd5, 5'd6);
    setStage(3, C_ALU, 5'd6, 5'd1, 5'd1);
    setStage(4, C_BR, 5'd0, 5'd1, 5'd2);
    brTaken = 1'b1; brTarget = 32'h0000_0240;
    expectComb("R9 redirect over stall", 1'b0, 4'b1110, 2'd2);
    expectPcAfterEdge("R9 target", 32'h0000_0240);
  endtask

  initial begin
    clearAll();
    @(negedge clk);
    testReset();
    testAdvance();
    testRawWindow();
    testNonProducers();
    testRegZero();
    testInvalid();
    testYounger();
    testTaken();
    testNotTaken();
    testPriority();
    clearAll();
    testAdvance();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule